// File: doc/BRIEF.md
# Configuration Port Address Decoder

This block sits on the I/O side of a core's memory pipeline. It takes each I/O port access and turns it into a physical request address. It implements the two-port scheme that reaches configuration space: a 32-bit configuration address register at port 0xCF8, and a four-byte data window at ports 0xCFC to 0xCFF. An access to the data window is redirected to a configuration-space address. That address is built from the stored register, but only while the register's enable bit (bit 31) is set. Every other port maps straight into a plain I/O region of the physical address map.

Each accepted request produces a one-cycle response. The response carries a target kind, a physical address and two flags. One flag marks a port number that is out of range. The other tells the requester to complete a dropped read with all ones. Region prefixes and address widths are parameters. Privilege checks, permission bitmaps and the configuration transaction itself belong to other blocks.

Top module: `pcicfg_port_decoder`

## Requirements
- R1: After reset, `rsp_valid` is low and the configuration address register holds zero, so the first data-window access is dropped.
- R2: A 4-byte access (`req_size`=4) to port 0xCF8 returns kind 1 (address register) with `rsp_addr` equal to `REG_ADDR`. A 4-byte write there loads `req_wdata` into the register.
- R3: An access to port 0xCF8 of size 1 or 2 is decoded as plain I/O (kind 0) and leaves the register unchanged.
- R4: An access to ports 0xCFC..0xCFF while register bit 31 is set returns kind 2 (configuration space). Its address is `CFG_PREFIX` ORed with register bits 30:2, kept in place, and the low two port bits in bits 1:0.
- R5: A data-window access while register bit 31 is clear returns kind 3 (dropped) with address zero. `rsp_fill_ones` is high for a read. A write there is discarded.
- R6: Any other port returns kind 0 (plain I/O) with address `IO_PREFIX` ORed with the 16-bit port number.
- R7: A port number with any bit above bit 15 set returns `rsp_err`=1, kind 3 and address zero, and never writes the register.
- R8: A response appears exactly one clock after a cycle with `req_valid` high. `rsp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_port | input | PORT_IN_W | Port number of the access |
| req_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, used only for the address register |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 0 plain I/O, 1 address register, 2 config space, 3 dropped |
| rsp_addr | output | PA_W | Physical request address |
| rsp_err | output | 1 | Port number out of the 16-bit range |
| rsp_fill_ones | output | 1 | Dropped read: return all ones |

## Verification
Some properties are checked by assertions on every cycle:
- the register changes only on a qualifying write;
- the classifier never raises two targets at once;
- a configuration-space response always carries its region prefix;
- an error response is always a dropped response.

Other behaviours only the bench's scenarios can show:
- a write of size 1 or 2 to 0xCF8 leaves the register unchanged;
- a write to a disabled data window is discarded;
- a later data-window access decodes from the most recently stored register value;
- the exact address field placement.

// File: rtl/pcicfg_pkg.sv
// Shared constants and types for the configuration port decoder.
// Assumes a 16-bit I/O port space.
package pcicfg_pkg;
    localparam int unsigned IO_PORT_W = 16;
    localparam logic [IO_PORT_W-1:0] CREG_PORT = 16'h0CF8;
    localparam logic [IO_PORT_W-1:0] WIN_BASE  = 16'h0CFC;
    localparam int unsigned CREG_W = 32;

    typedef enum logic [1:0] {
        KIND_PIO  = 2'd0,
        KIND_CREG = 2'd1,
        KIND_CFG  = 2'd2,
        KIND_DROP = 2'd3
    } tgt_kind_t;
endpackage

// File: rtl/pcicfg_port_classify.sv
// Classifies one port access as a range error, an address-register hit,
// a data-window hit or plain I/O. Purely combinational.
// Assumes req_size is a byte count of 1, 2 or 4.
module pcicfg_port_classify
    import pcicfg_pkg::*;
#(
    parameter int unsigned PORT_IN_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_IN_W-1:0] port,
    input  logic [2:0]           size,
    output logic                 is_err,
    output logic                 hit_creg,
    output logic                 hit_win,
    output logic [IO_PORT_W-1:0] port16
);
    localparam int unsigned HI_W = PORT_IN_W - IO_PORT_W;

    // Split the port into its legal and out-of-range parts, then decode.
    always_comb begin
        port16   = port[IO_PORT_W-1:0];
        is_err   = |port[PORT_IN_W-1:IO_PORT_W];
        hit_creg = !is_err && (port16 == CREG_PORT) && (size == 3'd4);
        hit_win  = !is_err && (port16[IO_PORT_W-1:2] == WIN_BASE[IO_PORT_W-1:2]);
    end

    // R7: an out-of-range port never also decodes as a target
    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_err, hit_creg, hit_win}));

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: rtl/pcicfg_addr_reg.sv
// Holds the 32-bit configuration address register.
// Assumes the caller asserts wr_en only for a qualified 4-byte write to the register port.
module pcicfg_addr_reg
    import pcicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CREG_W-1:0] wr_data,
    output logic [CREG_W-1:0] q
);
    // Load the register on a qualified write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

    // R3
    reg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> $past(wr_en));
endmodule

// File: rtl/pcicfg_addr_build.sv
// Builds the target kind and physical address for one classified access,
// using the current configuration address register. Combinational.
module pcicfg_addr_build
    import pcicfg_pkg::*;
#(
    parameter int unsigned PA_W = 40,
    parameter logic [PA_W-1:0] CFG_PREFIX = 40'h80_0000_0000,
    parameter logic [PA_W-1:0] IO_PREFIX  = 40'h40_0000_0000,
    parameter logic [PA_W-1:0] REG_ADDR   = 40'h20_0000_0000
) (
    input  logic                 is_err,
    input  logic                 hit_creg,
    input  logic                 hit_win,
    input  logic                 write,
    input  logic [IO_PORT_W-1:0] port16,
    input  logic [CREG_W-1:0]    creg,
    output tgt_kind_t            kind,
    output logic [PA_W-1:0]      addr,
    output logic                 fill_ones
);
    localparam int unsigned CFG_PAD = PA_W - (CREG_W - 1);
    localparam int unsigned IO_PAD  = PA_W - IO_PORT_W;

    logic [PA_W-1:0] cfg_addr;
    logic [PA_W-1:0] io_addr;

    // Form the two candidate addresses.
    always_comb begin
        cfg_addr = CFG_PREFIX | {{CFG_PAD{1'b0}}, creg[CREG_W-2:2], port16[1:0]};
        io_addr  = IO_PREFIX  | {{IO_PAD{1'b0}}, port16};
    end

    // Select the target; the error and disabled-window cases give a dropped access.
    always_comb begin
        kind      = KIND_PIO;
        addr      = io_addr;
        fill_ones = 1'b0;
        if (is_err) begin
            kind = KIND_DROP;
            addr = '0;
        end else if (hit_creg) begin
            kind = KIND_CREG;
            addr = REG_ADDR;
        end else if (hit_win) begin
            if (creg[CREG_W-1]) begin
                kind = KIND_CFG;
                addr = cfg_addr;
            end else begin
                kind      = KIND_DROP;
                addr      = '0;
                fill_ones = !write;
            end
        end
    end
endmodule

// File: rtl/pcicfg_port_decoder.sv
// Top of the configuration port decoder. It classifies each I/O access,
// updates the configuration address register and registers a one-cycle response.
// Assumes at most one access per cycle and a synchronous active-low reset.
module pcicfg_port_decoder
    import pcicfg_pkg::*;
#(
    parameter int unsigned PORT_IN_W = 32,
    parameter int unsigned PA_W = 40,
    parameter logic [PA_W-1:0] CFG_PREFIX = 40'h80_0000_0000,
    parameter logic [PA_W-1:0] IO_PREFIX  = 40'h40_0000_0000,
    parameter logic [PA_W-1:0] REG_ADDR   = 40'h20_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [PORT_IN_W-1:0] req_port,
    input  logic [2:0]           req_size,
    input  logic                 req_write,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_kind,
    output logic [PA_W-1:0]      rsp_addr,
    output logic                 rsp_err,
    output logic                 rsp_fill_ones
);
    logic                 is_err, hit_creg, hit_win;
    logic [IO_PORT_W-1:0] port16;
    logic [CREG_W-1:0]    creg;
    tgt_kind_t            kind_c;
    logic [PA_W-1:0]      addr_c;
    logic                 fill_c;
    logic                 creg_wr;

    pcicfg_port_classify #(.PORT_IN_W(PORT_IN_W)) classify_i (
        .clk(clk), .rst_n(rst_n), .port(req_port), .size(req_size),
        .is_err(is_err), .hit_creg(hit_creg), .hit_win(hit_win), .port16(port16)
    );

    // Qualify a register write: valid, write, 4-byte, register port.
    assign creg_wr = req_valid && req_write && hit_creg;

    pcicfg_addr_reg creg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(creg_wr), .wr_data(req_wdata), .q(creg)
    );

    pcicfg_addr_build #(
        .PA_W(PA_W), .CFG_PREFIX(CFG_PREFIX), .IO_PREFIX(IO_PREFIX), .REG_ADDR(REG_ADDR)
    ) build_i (
        .is_err(is_err), .hit_creg(hit_creg), .hit_win(hit_win), .write(req_write),
        .port16(port16), .creg(creg), .kind(kind_c), .addr(addr_c), .fill_ones(fill_c)
    );

    // Register the response one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_kind      <= KIND_PIO;
            rsp_addr      <= '0;
            rsp_err       <= 1'b0;
            rsp_fill_ones <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_kind      <= kind_c;
            rsp_addr      <= addr_c;
            rsp_err       <= req_valid && is_err;
            rsp_fill_ones <= req_valid && fill_c;
        end
    end

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R4
    cfg_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_CFG) |-> ((rsp_addr & CFG_PREFIX) == CFG_PREFIX));

    // R7
    err_is_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_kind == KIND_DROP && rsp_addr == '0));

    // R5
    fill_only_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fill_ones |-> (rsp_kind == KIND_DROP && !rsp_err));
endmodule

// File: tb/pcicfg_port_decoder_tb_top.sv
// Bench: a behavioural reference model, compared against the response after every clock.
module pcicfg_port_decoder_tb_top;
    localparam logic [39:0] M_CFG = 40'h80_0000_0000;
    localparam logic [39:0] M_IO  = 40'h40_0000_0000;
    localparam logic [39:0] M_REG = 40'h20_0000_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [31:0] req_port = 0;
    logic [2:0]  req_size = 4;
    logic        req_write = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, rsp_err, rsp_fill_ones;
    logic [1:0]  rsp_kind;
    logic [39:0] rsp_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    longint model_reg = 0;

    always #4 clk = ~clk;

    pcicfg_port_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
        .rsp_err(rsp_err), .rsp_fill_ones(rsp_fill_ones)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample 2 ns after the next posedge, then update the model.
    task automatic access(string req, longint port, int size, bit wr, longint data);
        int ek; longint ea; bit ee, ef;
        @(negedge clk);
        req_valid = 1; req_port = port[31:0]; req_size = size[2:0];
        req_write = wr; req_wdata = data[31:0];
        ee = (port >> 16) != 0; ef = 0; ea = 0; ek = 0;
        if (ee) ek = 3;
        else if (port == 'hCF8 && size == 4) begin ek = 1; ea = M_REG; end
        else if (port >= 'hCFC && port <= 'hCFF) begin
            if (model_reg[31]) begin
                ek = 2; ea = M_CFG + (model_reg & 'h7FFF_FFFC) + (port & 3);
            end else begin ek = 3; ef = !wr; end
        end else begin ek = 0; ea = M_IO + port; end
        @(posedge clk); #2;
        req_valid = 0;
        chk({req, " valid"}, rsp_valid, 1);
        chk({req, " kind"}, rsp_kind, ek);
        chk({req, " addr"}, rsp_addr, ea);
        chk({req, " err"}, rsp_err, ee);
        chk({req, " fill"}, rsp_fill_ones, ef);
        if (!ee && port == 'hCF8 && size == 4 && wr) model_reg = data & 'hFFFF_FFFF;
    endtask

    task automatic idle();
        @(negedge clk); req_valid = 0;
        @(posedge clk); #2;
        chk("R8 idle valid", rsp_valid, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2 chk("R1 reset valid", rsp_valid, 0);
        @(negedge clk); rst_n = 1;
        idle();
        access("R1 window after reset", 'hCFC, 4, 0, 0);
        access("R6 plain port", 'h0060, 1, 0, 0);
        access("R6 plain port hi", 'hFFFF, 2, 1, 0);
        access("R5 disabled window write", 'hCFE, 1, 1, 0);
        access("R2 reg read", 'hCF8, 4, 0, 0);
        access("R3 byte write cf8", 'hCF8, 1, 1, 'h8000_0000);
        access("R3 word write cf8", 'hCF8, 2, 1, 'h8000_0000);
        access("R3 register unchanged", 'hCFD, 1, 0, 0);
        access("R2 reg write", 'hCF8, 4, 1, 'h8012_3457);
        access("R4 window byte0", 'hCFC, 4, 0, 0);
        access("R4 window byte3", 'hCFF, 1, 1, 0);
        access("R7 high port", 'h1_0CF8, 4, 1, 'h0);
        access("R7 register kept", 'hCFD, 2, 0, 0);
        access("R2 disable", 'hCF8, 4, 1, 'h7FFF_FFFF);
        access("R5 disabled read", 'hCFF, 1, 0, 0);
        access("R6 near window", 'hCFB, 1, 0, 0);
        access("R6 near window above", 'hD00, 1, 0, 0);
        idle();
        for (int i = 0; i < 300; i++) begin
            longint p; int s; bit w; longint d;
            case ($urandom_range(0, 3))
                0: p = 'hCF8;
                1: p = 'hCFC + $urandom_range(0, 3);
                2: p = $urandom_range(0, 'hFFFF);
                default: p = $urandom_range(0, 7) << 16 | $urandom_range(0, 'hFFFF);
            endcase
            case ($urandom_range(0, 2)) 0: s = 1; 1: s = 2; default: s = 4; endcase
            w = $urandom_range(0, 1) == 1;
            d = $urandom();
            access("R4 mixed traffic", p, s, w, d);
            if (i % 17 == 0) idle();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule